// File: doc/BRIEF.md
# ATAPI PIO Read Transfer Sequencer

This block plays the device side of a packet command carried over the parallel ATA register set in programmed-I/O mode. The host programs a byte-count limit and issues the PACKET opcode. The sequencer then raises DRQ to collect a 12-byte command packet, which arrives as six 16-bit writes to the data register. If the packet is a READ(10), the block walks the requested logical blocks of 2048 bytes. It fetches 16-bit words from an attached block-data source and hands them to the host through the data register.

The data phase is cut into bursts. No burst is longer than the host's byte-count limit, and that limit is first rounded down to an even number. Before each burst the block writes the burst length back into the byte-count registers, raises its interrupt and shows DRQ. When the last word of the last burst has been read, it raises one more interrupt and returns to the ready state. A status-register read by the host clears the interrupt.

The block-data source is addressed by a registered logical block address and word index. It must return the matching word combinationally on `src_data`, and that word is presented unchanged on `data_out`.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset, status reads 0x40 (ready bit 6 only), the interrupt is low, the byte-count readback is 0, and the source address is block 0, word 0.
- R2: Writing 0xA0 to the command register (address 7) while idle, with feature bit 0 clear, gives status 0xC0 (busy bit 7 and ready) for one cycle and then 0x48 (ready and DRQ bit 3). At that moment the limit is latched from address 4 (low byte) and address 5 (high byte).
- R3: A PACKET command with feature bit 0 set (address 1, DMA requested) is ignored, and so is any other command byte: status stays 0x40 and no interrupt is raised.
- R4: In the packet phase, data-register writes (address 0) fill packet bytes 2i (low half) and 2i+1 (high half) for word i. After the sixth write, status is 0xC0 for one decode cycle.
- R5: For a packet whose byte 0 is 0x28, the start LBA is bytes 2..5 (big-endian) and the block count is bytes 7..8 (big-endian). Words are delivered in order from word 0 of the start block, and the block address advances after every 1024 words.
- R6: Each burst holds min(limit rounded down to even, remaining bytes) bytes, and a limit below 2 acts as 2. This size appears on the byte-count output when the burst's interrupt rises.
- R7: At every burst start the interrupt rises with status 0x48, so busy, error (bit 0) and fault (bit 5) are clear. Consecutive bursts are separated by one busy cycle of 0xC0.
- R8: One cycle after the final word is read, the interrupt rises again with status 0x40.
- R9: A status-read strobe clears a pending interrupt in the next cycle. A new interrupt raised in the same cycle takes precedence.
- R10: A packet whose opcode is not 0x28, or a READ(10) with a count of zero, completes with an interrupt and status 0x40, without a data phase.
- R11: Data-register reads outside a burst, and data writes outside the packet phase, do not move the source address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Register address of the write |
| host_wdata | input | 16 | Write data (8-bit registers use the low byte) |
| host_data_rd | input | 1 | Host reads one word from the data register |
| host_status_rd | input | 1 | Host reads status (clears interrupt) |
| data_out | output | 16 | Data register read value |
| status_out | output | 8 | Status register |
| bytecount_out | output | 16 | Byte-count register readback |
| irq_out | output | 1 | Interrupt request |
| src_lba | output | 32 | Logical block being read from the source |
| src_word | output | 10 | Word index within that block |
| src_data | input | 16 | Source word at src_lba/src_word |

## Verification
The assertions assume the host follows the handshake. It writes the data register only while DRQ is shown in the packet phase. It reads exactly the announced byte count divided by two words per burst, and it reads them only while DRQ is set. The source must answer combinationally. The bench host waits for the interrupt, reads status, and then reads exactly the announced number of words. It also injects stray data reads and writes while idle, which the requirements allow. The bench source returns a pattern built from the block and word index, so any misordered word or block step shows up as a data mismatch.

// File: rtl/atapi_pio_pkg.sv
package atapi_pio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACCEPT, ST_PACKET, ST_DECODE, ST_SIZE, ST_XFER
  } seq_state_e;

  localparam int unsigned PKT_WORDS = 6;

  localparam int unsigned STS_BSY  = 7;
  localparam int unsigned STS_DRDY = 6;
  localparam int unsigned STS_DRQ  = 3;

  localparam logic [7:0] OPC_PACKET = 8'hA0;
  localparam logic [7:0] OPC_READ10 = 8'h28;

  localparam logic [2:0] RA_DATA = 3'd0;
  localparam logic [2:0] RA_FEAT = 3'd1;
  localparam logic [2:0] RA_BCLO = 3'd4;
  localparam logic [2:0] RA_BCHI = 3'd5;
  localparam logic [2:0] RA_CMD  = 3'd7;

  function automatic logic [7:0] status_of(seq_state_e s);
    logic [7:0] v;
    v = '0;
    v[STS_DRDY] = 1'b1;
    case (s)
      ST_ACCEPT, ST_DECODE, ST_SIZE: v[STS_BSY] = 1'b1;
      ST_PACKET, ST_XFER:            v[STS_DRQ] = 1'b1;
      default: ;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/atapi_pkt_capture.sv
module atapi_pkt_capture
  import atapi_pio_pkg::*;
#(
  parameter int unsigned NWORDS = PKT_WORDS
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        push,
  input  logic [15:0] word,
  output logic        last_slot,
  output logic [7:0]  opcode,
  output logic [31:0] lba,
  output logic [15:0] nblk
);
  localparam int unsigned IDX_W = $clog2(NWORDS + 1);

  logic [15:0]      mem [NWORDS];
  logic [IDX_W-1:0] idx_q;
  logic             room;

  assign room      = (idx_q < IDX_W'(NWORDS));
  assign last_slot = (idx_q == IDX_W'(NWORDS - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) idx_q <= '0;
    else if (push && room) idx_q <= idx_q + 1'b1;
  end

  // storage without reset so it maps to distributed or block RAM
  always_ff @(posedge clk) begin
    if (push && room) mem[idx_q] <= word;
  end

  // byte 2i is the low half of word i; numeric fields are big-endian
  assign opcode = mem[0][7:0];
  assign lba    = {mem[1][7:0], mem[1][15:8], mem[2][7:0], mem[2][15:8]};
  assign nblk   = {mem[3][15:8], mem[4][7:0]};
endmodule

// File: rtl/atapi_burst_size.sv
module atapi_burst_size #(
  parameter int unsigned REM_W = 26
) (
  input  logic [15:0]      limit_bytes,
  input  logic [REM_W-1:0] rem_words,
  output logic [14:0]      burst_words
);
  logic [14:0] lim_words;

  always_comb begin
    lim_words = limit_bytes[15:1];
    if (lim_words == '0) lim_words = 15'd1;
    if (rem_words < REM_W'(lim_words)) burst_words = rem_words[14:0];
    else                               burst_words = lim_words;
  end
endmodule

// File: rtl/atapi_blk_addr.sv
module atapi_blk_addr #(
  parameter int unsigned WPB_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [31:0]      lba_in,
  input  logic             step,
  output logic [31:0]      lba,
  output logic [WPB_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lba  <= '0;
      word <= '0;
    end else if (load) begin
      lba  <= lba_in;
      word <= '0;
    end else if (step) begin
      word <= word + 1'b1;
      if (&word) lba <= lba + 1'b1;
    end
  end
endmodule

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq
  import atapi_pio_pkg::*;
#(
  parameter int unsigned BLOCK_BYTES = 2048,
  localparam int unsigned WPB_W = $clog2(BLOCK_BYTES / 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic [2:0]       host_addr,
  input  logic [15:0]      host_wdata,
  input  logic             host_data_rd,
  input  logic             host_status_rd,
  output logic [15:0]      data_out,
  output logic [7:0]       status_out,
  output logic [15:0]      bytecount_out,
  output logic             irq_out,
  output logic [31:0]      src_lba,
  output logic [WPB_W-1:0] src_word,
  input  logic [15:0]      src_data
);
  localparam int unsigned REM_W = 16 + WPB_W;

  seq_state_e       state_q, state_d;
  logic [7:0]       feat_q;
  logic [15:0]      bcount_q, limit_q;
  logic [REM_W-1:0] rem_q;
  logic [14:0]      left_q;
  logic             irq_q;
  logic [7:0]       status_q;

  logic        accept, push, pop, pkt_last, load_addr, irq_set, is_read;
  logic [7:0]  opcode;
  logic [31:0] pkt_lba;
  logic [15:0] nblk;
  logic [14:0] burst_words;

  assign accept = (state_q == ST_IDLE) && host_wr && (host_addr == RA_CMD) &&
                  (host_wdata[7:0] == OPC_PACKET) && !feat_q[0];
  assign push   = (state_q == ST_PACKET) && host_wr && (host_addr == RA_DATA);
  assign pop    = (state_q == ST_XFER) && host_data_rd;
  assign is_read = (opcode == OPC_READ10);

  atapi_pkt_capture #(.NWORDS(PKT_WORDS)) u_cap (
    .clk(clk), .rst(rst), .clear(accept), .push(push), .word(host_wdata),
    .last_slot(pkt_last), .opcode(opcode), .lba(pkt_lba), .nblk(nblk)
  );

  atapi_burst_size #(.REM_W(REM_W)) u_size (
    .limit_bytes(limit_q), .rem_words(rem_q), .burst_words(burst_words)
  );

  atapi_blk_addr #(.WPB_W(WPB_W)) u_addr (
    .clk(clk), .rst(rst), .load(load_addr), .lba_in(pkt_lba), .step(pop),
    .lba(src_lba), .word(src_word)
  );

  always_comb begin
    state_d   = state_q;
    irq_set   = 1'b0;
    load_addr = 1'b0;
    case (state_q)
      ST_IDLE:   if (accept) state_d = ST_ACCEPT;
      ST_ACCEPT: state_d = ST_PACKET;
      ST_PACKET: if (push && pkt_last) state_d = ST_DECODE;
      ST_DECODE: begin
        if (is_read && nblk != '0) begin
          state_d   = ST_SIZE;
          load_addr = 1'b1;
        end else begin
          state_d = ST_IDLE;
          irq_set = 1'b1;
        end
      end
      ST_SIZE: begin
        state_d = ST_XFER;
        irq_set = 1'b1;
      end
      ST_XFER: begin
        if (pop && left_q == 15'd1) begin
          if (rem_q == '0) begin
            state_d = ST_IDLE;
            irq_set = 1'b1;
          end else begin
            state_d = ST_SIZE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      status_q <= status_of(ST_IDLE);
      feat_q   <= '0;
      bcount_q <= '0;
      limit_q  <= '0;
      rem_q    <= '0;
      left_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      status_q <= status_of(state_d);
      irq_q    <= irq_set | (irq_q & ~host_status_rd);
      if (state_q == ST_IDLE && host_wr) begin
        case (host_addr)
          RA_FEAT: feat_q         <= host_wdata[7:0];
          RA_BCLO: bcount_q[7:0]  <= host_wdata[7:0];
          RA_BCHI: bcount_q[15:8] <= host_wdata[7:0];
          default: ;
        endcase
      end
      if (accept)    limit_q <= bcount_q;
      if (load_addr) rem_q   <= {nblk, {WPB_W{1'b0}}};
      if (state_q == ST_SIZE) begin
        bcount_q <= {burst_words, 1'b0};
        rem_q    <= rem_q - REM_W'(burst_words);
        left_q   <= burst_words;
      end else if (pop) begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign data_out      = src_data;
  assign status_out    = status_q;
  assign bytecount_out = bcount_q;
  assign irq_out       = irq_q;
endmodule

// File: rtl/atapi_pio_seq_chk.sv
module atapi_pio_seq_chk
  import atapi_pio_pkg::*;
#(
  parameter int unsigned WPB_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       status,
  input logic             irq,
  input logic             status_rd,
  input logic [15:0]      bcount,
  input seq_state_e       state,
  input logic [31:0]      src_lba,
  input logic [WPB_W-1:0] src_word
);
  p_bsy_drq_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(status[7] && status[3]));

  p_no_err_df_r7: assert property (@(posedge clk) disable iff (rst)
    !status[0] && !status[5]);

  p_accept_to_drq_r2: assert property (@(posedge clk) disable iff (rst)
    state == ST_ACCEPT |=> status == 8'h48);

  p_irq_rise_state_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (status == 8'h48 || status == 8'h40));

  p_irq_fall_ack_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(status_rd));

  p_burst_even_r6: assert property (@(posedge clk) disable iff (rst)
    state == ST_XFER |-> (!bcount[0] && bcount != 16'd0));

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!status[3] && !status[7]) |=> ($stable(src_word) && $stable(src_lba)));
endmodule

bind atapi_pio_seq atapi_pio_seq_chk #(.WPB_W(WPB_W)) i_chk (
  .clk(clk), .rst(rst), .status(status_out), .irq(irq_out),
  .status_rd(host_status_rd), .bcount(bytecount_out), .state(state_q),
  .src_lba(src_lba), .src_word(src_word)
);

// File: tb/test_atapi_pio_seq.sv
`timescale 1ns/1ps
module test_atapi_pio_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_data_rd = 1'b0;
  logic        host_status_rd = 1'b0;
  logic [15:0] data_out, bytecount_out, src_data;
  logic [7:0]  status_out;
  logic        irq_out;
  logic [31:0] src_lba;
  logic [9:0]  src_word;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] pat(longint lba, int word);
    return {lba[5:0], 10'(word)};
  endfunction

  assign src_data = pat(src_lba, int'(src_word));

  atapi_pio_seq i_atapi_pio_seq (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_data_rd(host_data_rd),
    .host_status_rd(host_status_rd), .data_out(data_out),
    .status_out(status_out), .bytecount_out(bytecount_out),
    .irq_out(irq_out), .src_lba(src_lba), .src_word(src_word),
    .src_data(src_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int          m_ph = 0;   // 0 idle,1 accept,2 packet,3 decode,4 size,5 data
  byte unsigned m_pkt[$];
  logic [7:0]  m_feat = 0;
  logic [15:0] m_bc = 0, m_lim = 0;
  bit          m_irq = 0;
  longint      m_lba = 0, m_rem = 0, m_left = 0;
  int          m_word = 0;

  function automatic logic [7:0] m_status();
    case (m_ph)
      0: return 8'h40;
      2, 5: return 8'h48;
      default: return 8'hC0;
    endcase
  endfunction

  task automatic m_step();
    bit set = 0;
    longint lim, b, cnt;
    case (m_ph)
      0: if (host_wr) begin
        if (host_addr == 1) m_feat = host_wdata[7:0];
        if (host_addr == 4) m_bc[7:0] = host_wdata[7:0];
        if (host_addr == 5) m_bc[15:8] = host_wdata[7:0];
        if (host_addr == 7 && host_wdata[7:0] == 8'hA0 && !m_feat[0]) begin
          m_lim = m_bc; m_ph = 1;
        end
      end
      1: begin m_ph = 2; m_pkt.delete(); end
      2: if (host_wr && host_addr == 0) begin
        m_pkt.push_back(host_wdata[7:0]);
        m_pkt.push_back(host_wdata[15:8]);
        if (m_pkt.size() == 12) m_ph = 3;
      end
      3: begin
        cnt = {m_pkt[7], m_pkt[8]};
        if (m_pkt[0] == 8'h28 && cnt != 0) begin
          m_lba = {m_pkt[2], m_pkt[3], m_pkt[4], m_pkt[5]};
          m_word = 0; m_rem = cnt * 2048; m_ph = 4;
        end else begin m_ph = 0; set = 1; end
      end
      4: begin
        lim = m_lim & 16'hFFFE;
        if (lim < 2) lim = 2;
        b = (m_rem < lim) ? m_rem : lim;
        m_bc = 16'(b); m_rem -= b; m_left = b; m_ph = 5; set = 1;
      end
      5: if (host_data_rd) begin
        m_word++;
        if (m_word == 1024) begin m_word = 0; m_lba = (m_lba + 1) & 32'hFFFFFFFF; end
        m_left -= 2;
        if (m_left == 0) begin
          if (m_rem == 0) begin m_ph = 0; set = 1; end
          else m_ph = 4;
        end
      end
      default: ;
    endcase
    if (set) m_irq = 1;
    else if (host_status_rd) m_irq = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_feat = 0; m_bc = 0; m_lim = 0; m_irq = 0;
      m_lba = 0; m_word = 0; m_rem = 0; m_left = 0;
    end else begin
      m_step();
      #1;
      if (!done) begin
        chk(status_out == m_status(), (m_ph == 5 || m_ph == 4) ? "R7 status" : "R2 R4 status",
            status_out, m_status());
        chk(irq_out == m_irq, "R9 irq", irq_out, m_irq);
        chk(bytecount_out == m_bc, "R6 bytecount", bytecount_out, m_bc);
        chk(src_lba == m_lba[31:0] && src_word == 10'(m_word), "R5 address",
            {src_lba, 6'd0, src_word}, {m_lba[31:0], 6'd0, 10'(m_word)});
        if (m_ph == 5)
          chk(data_out == pat(m_lba, m_word), "R5 data", data_out, pat(m_lba, m_word));
      end
    end
  end

  // ---------------- host tasks ----------------
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic ack();
    @(negedge clk); host_status_rd = 1;
    @(negedge clk); host_status_rd = 0;
    chk(irq_out == 0, "R9 ack clears irq", irq_out, 0);
  endtask

  task automatic issue(input logic [7:0] feat, input logic [15:0] lim);
    wr(1, {8'd0, feat});
    wr(4, {8'd0, lim[7:0]});
    wr(5, {8'd0, lim[15:8]});
    wr(7, 16'h00A0);
    chk(status_out == 8'hC0, "R2 busy after PACKET", status_out, 8'hC0);
    @(negedge clk);
    chk(status_out == 8'h48, "R2 DRQ for packet", status_out, 8'h48);
  endtask

  task automatic send_pkt(input logic [7:0] op, input logic [31:0] lba, input logic [15:0] cnt);
    byte unsigned b[12];
    foreach (b[i]) b[i] = 0;
    b[0] = op; b[2] = lba[31:24]; b[3] = lba[23:16]; b[4] = lba[15:8]; b[5] = lba[7:0];
    b[7] = cnt[15:8]; b[8] = cnt[7:0];
    for (int i = 0; i < 6; i++) wr(0, {b[2*i+1], b[2*i]});
    chk(status_out != 8'h48, "R4 packet phase left", status_out, 8'hC0);
  endtask

  task automatic wait_irq();
    do @(negedge clk); while (!irq_out && !done);
  endtask

  task automatic run_read(input logic [15:0] lim, input logic [31:0] lba, input int cnt);
    longint remb = longint'(cnt) * 2048, lime, exp;
    longint words = 0;
    int n;
    lime = lim & 16'hFFFE;
    if (lime < 2) lime = 2;
    issue(8'h00, lim);
    send_pkt(8'h28, lba, 16'(cnt));
    forever begin
      wait_irq();
      if (done) return;
      if (status_out == 8'h40) begin
        chk(words * 2 == longint'(cnt) * 2048, "R8 all words before completion", words * 2, cnt * 2048);
        chk(status_out == 8'h40, "R8 final status", status_out, 8'h40);
        ack();
        return;
      end
      exp = (remb < lime) ? remb : lime;
      chk(bytecount_out == 16'(exp), "R6 burst size", bytecount_out, exp);
      chk(status_out == 8'h48, "R7 burst status", status_out, 8'h48);
      n = int'(bytecount_out) / 2;
      ack();
      host_data_rd = 1;
      repeat (n) @(negedge clk);
      host_data_rd = 0;
      words += n; remb -= exp;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [9:0] w0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(status_out == 8'h40, "R1 reset status", status_out, 8'h40);
    chk(irq_out == 0, "R1 reset irq", irq_out, 0);
    chk(bytecount_out == 0, "R1 reset bytecount", bytecount_out, 0);

    // R3: DMA requested, then a foreign command byte
    wr(1, 16'h0001); wr(7, 16'h00A0);
    repeat (3) @(negedge clk);
    chk(status_out == 8'h40 && !irq_out, "R3 DMA PACKET ignored", status_out, 8'h40);
    wr(1, 16'h0000); wr(7, 16'h00EC);
    repeat (3) @(negedge clk);
    chk(status_out == 8'h40 && !irq_out, "R3 other command ignored", status_out, 8'h40);

    // R11: stray data access while idle
    w0 = src_word;
    @(negedge clk); host_data_rd = 1; @(negedge clk); host_data_rd = 0;
    wr(0, 16'hBEEF);
    @(negedge clk);
    chk(src_word == w0, "R11 idle access ignored", src_word, w0);

    run_read(16'd5120, 32'h0000_0010, 1);
    run_read(16'd5120, 32'h1234_567E, 4);
    run_read(16'd1001, 32'h0000_0003, 1);
    run_read(16'd0,    32'h0000_0020, 1);

    // R10: non-READ(10) opcode and zero count
    issue(8'h00, 16'd512);
    send_pkt(8'h12, 32'h0, 16'd1);
    wait_irq();
    chk(status_out == 8'h40, "R10 other opcode completes", status_out, 8'h40);
    ack();
    issue(8'h00, 16'd512);
    send_pkt(8'h28, 32'h5, 16'd0);
    wait_irq();
    chk(status_out == 8'h40, "R10 zero count completes", status_out, 8'h40);
    chk(bytecount_out == 16'd512, "R10 bytecount untouched", bytecount_out, 512);
    ack();

    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule